// File: doc/BRIEF.md
# Host-Side Radio Module Power Sequencer

This block sits in a host controller and owns the power life cycle of an attached radio module. It sinks the module's active-low power-enable line through an open-collector style output to switch the module on, and waits until the module reports that it has restarted before it accepts a shutdown. It also moves to the ready state after a fixed boot delay if no restart report arrives.

On a shutdown command the block pulls a shared open-drain shutdown line low for a timed pulse. It then lets the line go and watches it. The module first answers by holding the line low itself, and later lets it rise again when its own power-down is complete. Only then does the block release the power-enable line. If the module does not answer, or does not let go of the line, within programmable windows, the block raises an error flag and cuts power anyway.

After every power removal, and after reset, the block keeps the module off for a minimum time before it honours a new power-up request. All durations are counted in milliseconds from a tick prescaler, so the block fits any system clock.

Top module: `host_pwr_seq`

## Requirements
- R1: After reset `pwr_en_sink` is 0 (module unpowered), `sd_pull_low` is 0, `ready` is 0, `error` is 0 and `busy` is 1. A 1 on `pwr_en_sink` means the power-enable line is pulled low and the module is powered.
- R2: Whenever power is removed, and after reset, the block stays busy and ignores `power_up` for OFF_MS milliseconds (OFF_MS × TICK_DIV clock cycles). After that time `busy` falls to 0.
- R3: In the idle state (`busy`=0, `ready`=0) a `power_up` sampled high sets `pwr_en_sink` to 1 on the next clock, and `busy` stays 1 until ready.
- R4: While booting, `ready` rises one cycle after `restart_seen` is sampled high. If `restart_seen` never arrives, `ready` rises READY_MS milliseconds after power-up.
- R5: `shutdown` has an effect only while `ready` is 1. In any other state it does not drive the shutdown line and does not change the power output.
- R6: An accepted shutdown pulls `sd_pull_low` high for exactly PULSE_MS × TICK_DIV clock cycles. Power stays on during the pulse.
- R7: After the pulse the block takes the line as confirmed only once the synchronised line reads low after its own drive has ended. Power stays on while the module holds the line low.
- R8: Power is removed only after the module releases the line. `pwr_en_sink` falls within four cycles of `sd_line` going high, and `error` stays 0.
- R9: If no confirmation is seen within CONFIRM_TO_MS milliseconds after the pulse, `error` is set and power is removed at the same time.
- R10: If the line stays low for RELEASE_TO_MS milliseconds after confirmation, `error` is set and power is removed at the same time.
- R11: `error` stays set through the off time and clears when the next power-up is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| power_up | input | 1 | Request to power the module |
| shutdown | input | 1 | Request for an orderly shutdown |
| restart_seen | input | 1 | Module has reported its restart |
| sd_line | input | 1 | Sensed level of the shared shutdown line |
| sd_pull_low | output | 1 | 1 = sink the shutdown line |
| pwr_en_sink | output | 1 | 1 = sink the power-enable line (module on) |
| ready | output | 1 | Module powered and ready |
| busy | output | 1 | Sequence in progress or off time running |
| error | output | 1 | Last shutdown handshake timed out |

## Verification
The hardest case to reach is the moment right after the request pulse ends. There the line is still low from the host's own drive, and a careless design would take that low as the module's confirmation. The bench models the module with a separate open-drain driver on a wired-AND line. In the confirm-timeout scenario the module stays silent, so a design that sees its own echo as a confirmation would go on to the release phase and cut power early without setting `error`. Other scenarios hold the module's drive past the release window, and request power-up again during the off time.

// File: rtl/host_pwr_seq.sv
module host_pwr_seq #(
  parameter int TICK_DIV      = 125000,
  parameter int READY_MS      = 3000,
  parameter int PULSE_MS      = 100,
  parameter int OFF_MS        = 1000,
  parameter int CONFIRM_TO_MS = 500,
  parameter int RELEASE_TO_MS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic power_up,
  input  logic shutdown,
  input  logic restart_seen,
  input  logic sd_line,
  output logic sd_pull_low,
  output logic pwr_en_sink,
  output logic ready,
  output logic busy,
  output logic error
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 2;
  localparam int M1 = (READY_MS > PULSE_MS) ? READY_MS : PULSE_MS;
  localparam int M2 = (OFF_MS > CONFIRM_TO_MS) ? OFF_MS : CONFIRM_TO_MS;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MS_MAX = (M3 > RELEASE_TO_MS) ? M3 : RELEASE_TO_MS;
  localparam int MW = $clog2(MS_MAX + 1);

  typedef enum logic [2:0] {S_HOLD, S_IDLE, S_BOOT, S_RUN, S_PULSE, S_CONF, S_REL} st_t;

  st_t state, nxt;
  logic [PW-1:0] pre_cnt;
  logic [MW-1:0] ms_cnt;
  logic sync1, sync2, tick, settled, err_set;

  assign tick    = (pre_cnt == PW'(TICK_DIV - 1));
  assign settled = (ms_cnt != '0) || (pre_cnt >= PW'(2));

  function automatic logic at_ms(input logic [MW-1:0] c, input logic t, input int n);
    return t && (c == MW'(n - 1));
  endfunction

  always_comb begin
    nxt = state;
    err_set = 1'b0;
    case (state)
      S_HOLD:  if (at_ms(ms_cnt, tick, OFF_MS)) nxt = S_IDLE;
      S_IDLE:  if (power_up) nxt = S_BOOT;
      S_BOOT:  if (restart_seen || at_ms(ms_cnt, tick, READY_MS)) nxt = S_RUN;
      S_RUN:   if (shutdown) nxt = S_PULSE;
      S_PULSE: if (at_ms(ms_cnt, tick, PULSE_MS)) nxt = S_CONF;
      S_CONF: begin
        if (settled && !sync2) nxt = S_REL;
        else if (at_ms(ms_cnt, tick, CONFIRM_TO_MS)) begin
          nxt = S_HOLD;
          err_set = 1'b1;
        end
      end
      S_REL: begin
        if (sync2) nxt = S_HOLD;
        else if (at_ms(ms_cnt, tick, RELEASE_TO_MS)) begin
          nxt = S_HOLD;
          err_set = 1'b1;
        end
      end
      default: nxt = S_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_HOLD;
      pre_cnt <= '0;
      ms_cnt  <= '0;
      sync1   <= 1'b1;
      sync2   <= 1'b1;
      error   <= 1'b0;
    end else begin
      sync1 <= sd_line;
      sync2 <= sync1;
      state <= nxt;
      if (nxt != state) begin
        pre_cnt <= '0;
        ms_cnt  <= '0;
      end else begin
        pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        if (tick) ms_cnt <= ms_cnt + 1'b1;
      end
      if (err_set) error <= 1'b1;
      else if (state == S_IDLE && nxt == S_BOOT) error <= 1'b0;
    end
  end

  assign sd_pull_low = (state == S_PULSE);
  assign pwr_en_sink = (state == S_BOOT) || (state == S_RUN) || (state == S_PULSE) ||
                       (state == S_CONF) || (state == S_REL);
  assign ready       = (state == S_RUN);
  assign busy        = (state != S_RUN) && (state != S_IDLE);
endmodule

// File: rtl/host_pwr_seq_chk.sv
module host_pwr_seq_chk #(
  parameter int TICK_DIV = 125000,
  parameter int PULSE_MS = 100,
  parameter int OFF_MS   = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic sd_line,
  input logic sd_pull_low,
  input logic pwr_en_sink,
  input logic ready,
  input logic busy,
  input logic error
);
  localparam longint OFF_CYC   = longint'(OFF_MS) * TICK_DIV;
  localparam longint PULSE_CYC = longint'(PULSE_MS) * TICK_DIV;

  longint off_cnt, pulse_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cnt   <= 0;
      pulse_cnt <= 0;
    end else begin
      if (pwr_en_sink) off_cnt <= 0;
      else if (off_cnt < OFF_CYC) off_cnt <= off_cnt + 1;
      if (sd_pull_low) pulse_cnt <= pulse_cnt + 1;
      else pulse_cnt <= 0;
    end
  end

  assert_off_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en_sink) |-> off_cnt >= OFF_CYC);

  assert_ready_powered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (pwr_en_sink && !busy));

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_pull_low) |-> pulse_cnt == PULSE_CYC);

  assert_pulse_powered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sd_pull_low |-> pwr_en_sink);

  assert_off_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en_sink) |-> (error || $past(sd_line, 3)));

  assert_error_cuts_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> !pwr_en_sink);
endmodule

bind host_pwr_seq host_pwr_seq_chk #(
  .TICK_DIV(TICK_DIV), .PULSE_MS(PULSE_MS), .OFF_MS(OFF_MS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_line(sd_line), .sd_pull_low(sd_pull_low),
  .pwr_en_sink(pwr_en_sink), .ready(ready), .busy(busy), .error(error)
);

// File: tb/host_pwr_seq_tb.sv
module host_pwr_seq_tb;
  localparam int DIV = 4, RDY = 20, PUL = 10, OFF = 15, CTO = 8, RTO = 30;

  logic clk = 0, rst_n = 0;
  logic power_up = 0, shutdown = 0, restart_seen = 0, mod_low = 0;
  logic sd_line, sd_pull_low, pwr_en_sink, ready, busy, error;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  assign sd_line = !(sd_pull_low || mod_low);

  host_pwr_seq #(.TICK_DIV(DIV), .READY_MS(RDY), .PULSE_MS(PUL), .OFF_MS(OFF),
                 .CONFIRM_TO_MS(CTO), .RELEASE_TO_MS(RTO)) u_dut (
    .clk(clk), .rst_n(rst_n), .power_up(power_up), .shutdown(shutdown),
    .restart_seen(restart_seen), .sd_line(sd_line), .sd_pull_low(sd_pull_low),
    .pwr_en_sink(pwr_en_sink), .ready(ready), .busy(busy), .error(error));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_in(ref logic s);
    s = 1; cyc(1); s = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 200) begin cyc(1); n++; end
  endtask

  task automatic t_reset();
    cyc(1);
    chk(pwr_en_sink == 0 && sd_pull_low == 0, "R1 outputs off", pwr_en_sink, 0);
    chk(busy == 1 && ready == 0 && error == 0, "R1 status", {busy, ready, error}, 3'b100);
  endtask

  task automatic t_hold_after_reset();
    pulse_in(power_up);
    cyc(2);
    chk(pwr_en_sink == 0, "R2 power_up ignored in off time", pwr_en_sink, 0);
    cyc(OFF * DIV);
    chk(busy == 0 && pwr_en_sink == 0, "R2 idle after off time", busy, 0);
  endtask

  task automatic t_shutdown_not_ready();
    pulse_in(power_up);
    chk(pwr_en_sink == 1 && busy == 1 && ready == 0, "R3 power on", pwr_en_sink, 1);
    pulse_in(shutdown);
    cyc(2);
    chk(sd_pull_low == 0 && pwr_en_sink == 1, "R5 shutdown ignored while booting", sd_pull_low, 0);
    restart_seen = 1; cyc(1); restart_seen = 0;
    chk(ready == 1 && busy == 0, "R4 ready after restart report", ready, 1);
  endtask

  task automatic t_normal_shutdown();
    int n = 0;
    pulse_in(shutdown);
    while (sd_pull_low && n < 1000) begin n++; cyc(1); end
    chk(n == PUL * DIV, "R6 pulse length", n, PUL * DIV);
    cyc(5);
    chk(pwr_en_sink == 1, "R7 power held awaiting confirm", pwr_en_sink, 1);
    mod_low = 1; cyc(10);
    chk(pwr_en_sink == 1 && error == 0, "R7 power held while module low", pwr_en_sink, 1);
    mod_low = 0; cyc(1);
    chk(pwr_en_sink == 1, "R8 not yet off right after release", pwr_en_sink, 1);
    cyc(3);
    chk(pwr_en_sink == 0 && error == 0, "R8 off after release", pwr_en_sink, 0);
  endtask

  task automatic t_off_time();
    int n = 0;
    power_up = 1;
    while (!pwr_en_sink && n < 500) begin n++; cyc(1); end
    power_up = 0;
    chk(n >= OFF * DIV && n <= OFF * DIV + 3, "R2 off time before power-up", n, OFF * DIV);
  endtask

  task automatic t_boot_fallback();
    cyc(RDY * DIV - 4);
    chk(ready == 0, "R4 not ready before boot delay", ready, 0);
    cyc(6);
    chk(ready == 1, "R4 ready after boot delay", ready, 1);
  endtask

  task automatic t_confirm_timeout();
    pulse_in(shutdown);
    cyc(PUL * DIV + CTO * DIV - 8);
    chk(pwr_en_sink == 1 && error == 0, "R9 before confirm timeout", error, 0);
    cyc(12);
    chk(pwr_en_sink == 0 && error == 1, "R9 confirm timeout error", error, 1);
    wait_idle();
    chk(error == 1, "R11 error held through off time", error, 1);
    pulse_in(power_up);
    chk(error == 0 && pwr_en_sink == 1, "R11 error cleared on power-up", error, 0);
    restart_seen = 1; cyc(1); restart_seen = 0;
  endtask

  task automatic t_release_timeout();
    pulse_in(shutdown);
    cyc(PUL * DIV + 3);
    mod_low = 1;
    cyc(RTO * DIV - 10);
    chk(pwr_en_sink == 1 && error == 0, "R10 before release timeout", error, 0);
    cyc(16);
    chk(pwr_en_sink == 0 && error == 1, "R10 release timeout error", error, 1);
    mod_low = 0;
  endtask

  initial begin
    cyc(3); rst_n = 1;
    t_reset();
    t_hold_after_reset();
    t_shutdown_not_ready();
    t_normal_shutdown();
    t_off_time();
    t_boot_fallback();
    t_confirm_timeout();
    t_release_timeout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule